// File: doc/BRIEF.md
# Flash Event Status and Interrupt Unit

This unit gathers six event pulses from a flash memory controller and turns them into one interrupt line. The events are device ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. Each pulse sets a bit in a sticky flag register. That register keeps its bits until software reads it, and the read clears them all. A mask register selects which flags may drive the interrupt. The interrupt output is a level signal, active high, and it is registered once.

A second read-only word reports the live conditions: device ready, controller ready, ECC ready, errors detected, decoder failure, and an encoded count of corrected errors. A separate output gives the combined device-ready condition.

Software reaches the unit through a small register port. The port has a select field, a write strobe and a read strobe. Read data is returned in the same cycle as the select.

Top module: `flash_event_irq`

## Requirements
- R1: After reset the mask register reads 0, the sticky flag register reads 0, and `irq_o` is 0.
- R2: A 1 on `evt_i[k]` at a clock edge sets sticky flag bit k. Bit 0 is write-protect fault, bit 1 ECC ready, bit 2 decode error, bit 3 decode failure, bit 4 controller ready and bit 5 device ready. The bit stays set until the sticky register is read.
- R3: A read of the sticky register (select 1 with `rd_en_i`) returns the flags held before that edge, and it clears every flag at that edge.
- R4: An event that arrives at the same edge as a sticky read remains set after the read.
- R5: A write with select 0 loads the mask from `wdata_i[5:0]`. Reads of select 0 return the mask with bits 7:6 at zero. The mask changes only on such a write.
- R6: `irq_o` equals the OR of (sticky AND mask) as it was one clock earlier.
- R7: A flag whose mask bit is 0 is still latched, but it does not raise `irq_o`.
- R8: Select 2 returns the live word: device ready in bit 0, controller ready in bit 1, ECC ready in bit 2, errors detected in bit 3, decoder failure in bit 6, and bit 7 at zero.
- R9: Live bits 5:4 carry `err_cnt_i` (the corrected count minus one) when errors detected is 1, and they read 0 when it is 0.
- R10: `dev_ready_o` is 1 exactly when both device ready and controller ready are 1.
- R11: Select 3 reads 0. Writes to selects 1, 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 2 | Register select: 0 mask, 1 sticky flags, 2 live word |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; clears the sticky flags when select is 1 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current select |
| evt_i | input | 6 | Event pulses, one bit per source |
| nand_rdy_i | input | 1 | Live device ready |
| ctl_rdy_i | input | 1 | Live controller ready |
| ecc_rdy_i | input | 1 | Live ECC ready |
| err_seen_i | input | 1 | Live errors detected |
| dec_fail_i | input | 1 | Live decoder failure |
| err_cnt_i | input | 2 | Corrected error count minus one |
| irq_o | output | 1 | Interrupt, active high level |
| dev_ready_o | output | 1 | Device and controller both ready |

## Verification
The assertions assume that reset is synchronous and that select, strobes and events settle between clock edges. They also assume that a sticky-clear check happens only in a cycle with no incoming events. The bench drives every input at the falling edge, so each value holds across the next rising edge. It raises the read strobe and the write strobe in separate cycles. It sweeps all 64 masks against every single source, which covers both masked and unmasked flags. It also sweeps all 128 combinations of the live inputs.

// File: rtl/flash_event_pkg.sv
package flash_event_pkg;
   // sticky / mask bit positions (decoded by software, fixed)
   localparam int EV_WP_FAULT  = 0;
   localparam int EV_ECC_RDY   = 1;
   localparam int EV_DEC_ERR   = 2;
   localparam int EV_DEC_FAIL  = 3;
   localparam int EV_CTL_RDY   = 4;
   localparam int EV_NAND_RDY  = 5;
   localparam int EV_COUNT     = 6;

   // live word positions
   localparam int LV_NAND_RDY  = 0;
   localparam int LV_CTL_RDY   = 1;
   localparam int LV_ECC_RDY   = 2;
   localparam int LV_ERR_SEEN  = 3;
   localparam int LV_CNT_LSB   = 4;

   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_STICKY = 2'd1,
      SEL_LIVE   = 2'd2,
      SEL_NONE   = 2'd3
   } evt_sel_e;
endpackage

// File: rtl/evt_sticky_bank.sv
// Sticky flag bank: set by pulses, cleared as a whole by a read strobe.
module evt_sticky_bank #(
   parameter int N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic             clr_i,
   output logic [N_SRC-1:0] flags_o
);
   generate
      for (genvar b = 0; b < N_SRC; b++) begin : g_bit
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= (q & ~clr_i) | set_i[b];   // R4: set wins over clear
         end
         assign flags_o[b] = q;
      end
   endgenerate
endmodule

// File: rtl/evt_irq_gate.sv
// Mask gate and interrupt reduction; output stage chosen by parameter.
module evt_irq_gate #(
   parameter int N_SRC   = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] flags_i,
   input  logic [N_SRC-1:0] mask_i,
   output logic             irq_o
);
   logic [N_SRC-1:0] gated;
   logic             any_hit;

   assign gated   = flags_i & mask_i;
   assign any_hit = |gated;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= any_hit;   // R6
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = any_hit;
      end
   endgenerate
endmodule

// File: rtl/live_status_pack.sv
// Packs live conditions into the status word.
module live_status_pack
   import flash_event_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic              nand_rdy_i,
   input  logic              ctl_rdy_i,
   input  logic              ecc_rdy_i,
   input  logic              err_seen_i,
   input  logic              dec_fail_i,
   input  logic [CNT_W-1:0]  err_cnt_i,
   output logic [DATA_W-1:0] word_o,
   output logic              ready_o
);
   localparam int FAIL_POS = LV_CNT_LSB + CNT_W;

   always_comb begin
      word_o                           = '0;
      word_o[LV_NAND_RDY]              = nand_rdy_i;
      word_o[LV_CTL_RDY]               = ctl_rdy_i;
      word_o[LV_ECC_RDY]               = ecc_rdy_i;
      word_o[LV_ERR_SEEN]              = err_seen_i;
      // R9: count only meaningful with errors detected
      word_o[LV_CNT_LSB +: CNT_W]      = err_seen_i ? err_cnt_i : '0;
      word_o[FAIL_POS]                 = dec_fail_i;
   end

   // R10
   assign ready_o = nand_rdy_i & ctl_rdy_i;
endmodule

// File: rtl/flash_event_irq.sv
// Event latch, mask, interrupt and live status unit.
module flash_event_irq
   import flash_event_pkg::*;
#(
   parameter int N_SRC   = EV_COUNT,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 2,
   parameter int CNT_W   = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sel_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic              nand_rdy_i,
   input  logic              ctl_rdy_i,
   input  logic              ecc_rdy_i,
   input  logic              err_seen_i,
   input  logic              dec_fail_i,
   input  logic [CNT_W-1:0]  err_cnt_i,
   output logic              irq_o,
   output logic              dev_ready_o
);
   localparam int LIVE_BITS = LV_CNT_LSB + CNT_W + 1;

   generate
      if (N_SRC > DATA_W) begin : g_bad_src
         $error("N_SRC must fit in DATA_W");
      end
      if (LIVE_BITS > DATA_W) begin : g_bad_live
         $error("live word does not fit in DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [N_SRC-1:0]  mask_q;
   logic [N_SRC-1:0]  sticky_q;
   logic [DATA_W-1:0] live_word;
   logic              hit_mask;
   logic              hit_sticky;
   logic              hit_live;
   logic              sticky_rd;
   logic              unused_wdata;

   assign hit_mask   = (sel_i == ADDR_W'(SEL_MASK));
   assign hit_sticky = (sel_i == ADDR_W'(SEL_STICKY));
   assign hit_live   = (sel_i == ADDR_W'(SEL_LIVE));
   assign sticky_rd  = rd_en_i & hit_sticky;   // R3

   generate
      if (DATA_W > N_SRC) begin : g_wd_spare
         assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];
      end else begin : g_wd_full
         assign unused_wdata = 1'b0;
      end
   endgenerate

   // R5: mask register, written only at its own select
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_en_i && hit_mask)
         mask_q <= wdata_i[N_SRC-1:0];
   end

   evt_sticky_bank #(.N_SRC(N_SRC)) u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (evt_i),
      .clr_i   (sticky_rd),
      .flags_o (sticky_q)
   );

   evt_irq_gate #(.N_SRC(N_SRC), .IRQ_REG(IRQ_REG)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (sticky_q),
      .mask_i  (mask_q),
      .irq_o   (irq_o)
   );

   live_status_pack #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_live (
      .nand_rdy_i (nand_rdy_i),
      .ctl_rdy_i  (ctl_rdy_i),
      .ecc_rdy_i  (ecc_rdy_i),
      .err_seen_i (err_seen_i),
      .dec_fail_i (dec_fail_i),
      .err_cnt_i  (err_cnt_i),
      .word_o     (live_word),
      .ready_o    (dev_ready_o)
   );

   // R11: unmapped selects read zero
   always_comb begin
      rdata_o = '0;
      if (hit_mask)
         rdata_o[N_SRC-1:0] = mask_q;
      else if (hit_sticky)
         rdata_o[N_SRC-1:0] = sticky_q;
      else if (hit_live)
         rdata_o = live_word;
   end
endmodule

// File: rtl/flash_event_irq_chk.sv
module flash_event_irq_chk
   import flash_event_pkg::*;
#(
   parameter int N_SRC   = 6,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sel_i,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [N_SRC-1:0]  evt_i,
   input logic [N_SRC-1:0]  sticky,
   input logic [N_SRC-1:0]  mask,
   input logic [DATA_W-1:0] rdata_o,
   input logic              err_seen_i,
   input logic              irq_o
);
   logic rd_st;
   assign rd_st = rd_en_i && (sel_i == ADDR_W'(SEL_STICKY));

   // R2
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((sticky & $past(evt_i)) == $past(evt_i)));

   // R3
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_st && evt_i == '0) |=> (sticky == '0));

   // R4
   rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_st && (|evt_i)) |=> (sticky == $past(evt_i)));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && sel_i == ADDR_W'(SEL_MASK)) |=> $stable(mask));

   // R9
   cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == ADDR_W'(SEL_LIVE) && !err_seen_i) |-> (rdata_o[5:4] == 2'b00));

   generate
      if (IRQ_REG) begin : g_irq
         // R6
         irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(|(sticky & mask))));
      end
   endgenerate
endmodule

bind flash_event_irq flash_event_irq_chk #(
   .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_i      (sel_i),
   .wr_en_i    (wr_en_i),
   .rd_en_i    (rd_en_i),
   .evt_i      (evt_i),
   .sticky     (sticky_q),
   .mask       (mask_q),
   .rdata_o    (rdata_o),
   .err_seen_i (err_seen_i),
   .irq_o      (irq_o)
);

// File: tb/flash_event_irq_bench.sv
module flash_event_irq_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel_i = 2'd0;
   logic       wr_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [7:0] wdata_i = 8'd0;
   logic [7:0] rdata_o;
   logic [5:0] evt_i = 6'd0;
   logic       nand_rdy_i = 1'b0;
   logic       ctl_rdy_i = 1'b0;
   logic       ecc_rdy_i = 1'b0;
   logic       err_seen_i = 1'b0;
   logic       dec_fail_i = 1'b0;
   logic [1:0] err_cnt_i = 2'd0;
   logic       irq_o;
   logic       dev_ready_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_event_irq u_flash_event_irq (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_en_i),
      .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .evt_i(evt_i), .nand_rdy_i(nand_rdy_i), .ctl_rdy_i(ctl_rdy_i),
      .ecc_rdy_i(ecc_rdy_i), .err_seen_i(err_seen_i),
      .dec_fail_i(dec_fail_i), .err_cnt_i(err_cnt_i),
      .irq_o(irq_o), .dev_ready_o(dev_ready_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nedge();
      @(negedge clk);
   endtask

   task automatic peek(input logic [1:0] s, output logic [7:0] v);
      sel_i = s;
      #1;
      v = rdata_o;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) nedge();
      rst_n = 1'b1;
      nedge();
      // R1
      peek(2'd0, v); chk("R1 mask", v, 0);
      peek(2'd1, v); chk("R1 sticky", v, 0);
      chk("R1 irq", irq_o, 0);

      // R5 / R11: mask readback and ignored writes
      wr_en_i = 1; sel_i = 2'd0; wdata_i = 8'hFF; nedge();
      wr_en_i = 0; peek(2'd0, v); chk("R5 mask ff", v, 8'h3F);
      wr_en_i = 1; sel_i = 2'd1; wdata_i = 8'h15; nedge();
      sel_i = 2'd2; nedge();
      sel_i = 2'd3; nedge();
      wr_en_i = 0;
      peek(2'd0, v); chk("R11 mask kept", v, 8'h3F);
      peek(2'd1, v); chk("R11 sticky kept", v, 0);
      peek(2'd3, v); chk("R11 unmapped", v, 0);
      chk("R11 irq quiet", irq_o, 0);

      // R2 R3 R6 R7: every mask against every source
      for (int m = 0; m < 64; m++) begin
         for (int s = 0; s < 6; s++) begin
            logic [5:0] one;
            one = 6'(1) << s;
            wr_en_i = 1; sel_i = 2'd0; wdata_i = 8'(m); nedge();
            wr_en_i = 0; evt_i = one; nedge();
            evt_i = 0;
            chk("R6 lag", irq_o, 0);
            nedge();
            chk(m[s] ? "R6 irq" : "R7 masked", irq_o, 32'(m[s]));
            peek(2'd1, v); chk("R2 latch", v, 32'(one));
            rd_en_i = 1; nedge();
            rd_en_i = 0;
            chk("R6 hold", irq_o, 32'(m[s]));
            peek(2'd1, v); chk("R3 cleared", v, 0);
            nedge();
            chk("R3 irq drop", irq_o, 0);
         end
      end

      // R4: event during read
      evt_i = 6'b000001; nedge();
      evt_i = 6'b100000; sel_i = 2'd1; rd_en_i = 1; #1;
      chk("R3 read value", rdata_o, 8'h01);
      nedge();
      evt_i = 0; rd_en_i = 0;
      peek(2'd1, v); chk("R4 kept", v, 8'h20);
      rd_en_i = 1; nedge(); rd_en_i = 0;

      // R8 R9 R10: live sweep
      for (int c = 0; c < 128; c++) begin
         logic [7:0] ex;
         logic [6:0] b;
         b = 7'(c);
         nand_rdy_i = b[0]; ctl_rdy_i = b[1]; ecc_rdy_i = b[2];
         err_seen_i = b[3]; dec_fail_i = b[4]; err_cnt_i = b[6:5];
         peek(2'd2, v);
         ex = {1'b0, b[4], (b[3] ? b[6:5] : 2'b00), b[3], b[2], b[1], b[0]};
         chk(b[3] ? "R8 live" : "R9 live nocnt", v, 32'(ex));
         chk("R10 ready", dev_ready_o, 32'(b[0] & b[1]));
         nedge();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule